// File: doc/BRIEF.md
# Streaming Matrix Multiply Coprocessor

This block computes the product C = A x B of two square N x N matrices of signed W-bit integers. A host feeds it through one valid/ready input port that carries one element per transfer. All of matrix A is written first and is then kept inside the block. After that, the elements of B are streamed in column order. Each B element drives N parallel multiply-accumulate units. A counter that wraps modulo N gives the element's position inside its column, and that position selects the matching column of A.

When the last element of a B column arrives, the N finished sums are copied into a result buffer. The buffer is drained one element per transfer through a valid/ready output port. While it drains, the block keeps accumulating the next column. The input only stalls when a column is ready to close and the buffer is still occupied.

Back-pressure works as follows. An element moves only on a clock edge where valid and ready are both high. `in_ready` never depends on `in_valid`. A held output keeps `out_data` and `out_last` stable until `out_ready` rises. After the final column has drained, the block stays idle with matrix A retained, and a `start` pulse accepts a fresh B.

Top module: `matmul_stream_cop`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1 and `out_valid` is 0. The first N*N accepted input words are A in row-major order: word r*N+c is A[r][c].
- R2: No output is offered while A is loading or while the first B column is still incomplete.
- R3: The word accepted at column-major index j*N+k after A is B[k][j]. Output element i of column j equals the signed sum over k of A[i][k]*B[k][j]. It is reported at full width 2*W+clog2(N), so extreme operands of -2^(W-1) never overflow.
- R4: Results leave column by column, and each column in row order C[0][j] up to C[N-1][j].
- R5: `out_last` is 1 only together with `out_valid`, on C[N-1][N-1], and never on any other element.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R7: While a previous column is still in the result buffer, the first N-1 elements of the next column are accepted. `in_ready` is 0 for the column's last element until the buffer has fully drained.
- R8: After the final column is accepted, `in_ready` stays 0 and, once the last result has left, `out_valid` stays 0 until a `start` pulse. After `start`, a new B is multiplied by the retained A.
- R9: A `start` pulse while A is loading or while B is streaming has no effect on the accepted data or the results.
- R10: Reset in the middle of a run empties the result buffer and returns the block to loading A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Re-arm pulse, honoured only when idle after a full product |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the input word on this edge |
| in_data | input | W | Signed matrix element (A first, then B) |
| out_valid | output | 1 | Result element present |
| out_ready | input | 1 | Host takes the result element on this edge |
| out_data | output | 2*W+clog2(N) | Signed result element |
| out_last | output | 1 | Marks the final element of the final column |

## Verification
The bench uses N=4 and W=8. With these values a whole product is 16 A words, 16 B words and 16 results, so every element position, the column wrap and the last-flag position appear in each run within a few dozen cycles. At W=8 the all-minus-128 operands drive each sum to its maximum magnitude of 65536. Several runs also cover output stall patterns, a fully blocked output that exposes the input stall on a column's last element, start pulses in each phase, and a reset in the middle of streaming.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    PH_LOAD_A   = 2'd0,
    PH_STREAM_B = 2'd1,
    PH_DRAIN    = 2'd2,
    PH_DONE     = 2'd3
  } phase_t;
endpackage

// File: rtl/mm_a_regfile.sv
// Resident storage for the left operand; presents one column at a time.
module mm_a_regfile #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int KW = $clog2(N)
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [KW-1:0]   wr_row,
  input  logic [KW-1:0]   wr_col,
  input  logic [W-1:0]    wr_data,
  input  logic [KW-1:0]   sel_col,
  output logic [N*W-1:0]  col_flat
);
  logic [W-1:0] mem [N][N];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row][wr_col] <= wr_data;
  end

  for (genvar i = 0; i < N; i++) begin : g_col
    assign col_flat[i*W +: W] = mem[i][sel_col];
  end
endmodule

// File: rtl/mm_mac_bank.sv
// N multiply-accumulate lanes sharing one right-hand operand.
module mm_mac_bank #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int AW = 2*W + $clog2(N),
  localparam int PW  = 2*W,
  localparam int EXT = AW - PW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            first,
  input  logic [N*W-1:0]  a_flat,
  input  logic [W-1:0]    b_val,
  output logic [N*AW-1:0] sum_flat
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] base;
    logic signed [AW-1:0] sum;
    logic signed [AW-1:0] acc_q;

    assign prod = $signed(a_flat[i*W +: W]) * $signed(b_val);
    assign base = first ? '0 : acc_q;
    assign sum  = base + $signed({{EXT{prod[PW-1]}}, prod});
    assign sum_flat[i*AW +: AW] = sum;

    always_ff @(posedge clk) begin
      if (rst)     acc_q <= '0;
      else if (en) acc_q <= sum;
    end
  end
endmodule

// File: rtl/mm_result_buf.sv
// One-column result buffer drained in row order.
module mm_result_buf #(
  parameter int N  = 4,
  parameter int AW = 18,
  localparam int KW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [N*AW-1:0] load_flat,
  input  logic            out_ready,
  output logic            full,
  output logic            rd_last,
  output logic [AW-1:0]   out_data
);
  logic [N*AW-1:0] store_q;
  logic [KW-1:0]   rd_q;
  logic [AW-1:0]   view [N];

  for (genvar i = 0; i < N; i++) begin : g_view
    assign view[i] = store_q[i*AW +: AW];
  end

  assign rd_last  = (rd_q == KW'(N-1));
  assign out_data = view[rd_q];

  always_ff @(posedge clk) begin
    if (load) store_q <= load_flat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      rd_q <= '0;
    end else if (load) begin
      full <= 1'b1;
      rd_q <= '0;
    end else if (full && out_ready) begin
      if (rd_last) begin
        full <= 1'b0;
        rd_q <= '0;
      end else begin
        rd_q <= rd_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/matmul_stream_cop.sv
module matmul_stream_cop #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int KW    = $clog2(N),
  localparam int ACC_W = 2*W + $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_data,
  output logic             out_last
);
  import mm_pkg::*;

  phase_t          phase_q;
  logic [KW-1:0]   ld_row_q, ld_col_q;
  logic [KW-1:0]   b_k_q, b_col_q;
  logic            a_we, b_fire, buf_load, buf_full, rd_last;
  logic            k_end, col_end;
  logic [N*W-1:0]  a_col;
  logic [N*ACC_W-1:0] sums;

  assign k_end    = (b_k_q == KW'(N-1));
  assign col_end  = (b_col_q == KW'(N-1));
  assign in_ready = (phase_q == PH_LOAD_A) ||
                    ((phase_q == PH_STREAM_B) && (!k_end || !buf_full));
  assign a_we     = (phase_q == PH_LOAD_A) && in_valid;
  assign b_fire   = (phase_q == PH_STREAM_B) && in_valid && in_ready;
  assign buf_load = b_fire && k_end;
  assign out_valid = buf_full;
  assign out_last  = buf_full && rd_last && (phase_q == PH_DRAIN);

  mm_a_regfile #(.N(N), .W(W)) a_rf_i (
    .clk(clk), .wr_en(a_we), .wr_row(ld_row_q), .wr_col(ld_col_q),
    .wr_data(in_data), .sel_col(b_k_q), .col_flat(a_col)
  );

  mm_mac_bank #(.N(N), .W(W), .AW(ACC_W)) mac_i (
    .clk(clk), .rst(rst), .en(b_fire), .first(b_k_q == '0),
    .a_flat(a_col), .b_val(in_data), .sum_flat(sums)
  );

  mm_result_buf #(.N(N), .AW(ACC_W)) rbuf_i (
    .clk(clk), .rst(rst), .load(buf_load), .load_flat(sums),
    .out_ready(out_ready), .full(buf_full), .rd_last(rd_last),
    .out_data(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_LOAD_A;
      ld_row_q <= '0;
      ld_col_q <= '0;
      b_k_q    <= '0;
      b_col_q  <= '0;
    end else begin
      case (phase_q)
        PH_LOAD_A: if (a_we) begin
          if (ld_col_q == KW'(N-1)) begin
            ld_col_q <= '0;
            if (ld_row_q == KW'(N-1)) begin
              ld_row_q <= '0;
              phase_q  <= PH_STREAM_B;
            end else begin
              ld_row_q <= ld_row_q + 1'b1;
            end
          end else begin
            ld_col_q <= ld_col_q + 1'b1;
          end
        end
        PH_STREAM_B: if (b_fire) begin
          if (k_end) begin
            b_k_q <= '0;
            if (col_end) begin
              b_col_q <= '0;
              phase_q <= PH_DRAIN;
            end else begin
              b_col_q <= b_col_q + 1'b1;
            end
          end else begin
            b_k_q <= b_k_q + 1'b1;
          end
        end
        PH_DRAIN: if (buf_full && out_ready && rd_last) phase_q <= PH_DONE;
        default:  if (start) phase_q <= PH_STREAM_B;
      endcase
    end
  end
endmodule

// File: rtl/mm_cop_checker.sv
module mm_cop_checker #(
  parameter int AW = 18
) (
  input logic           clk,
  input logic           rst,
  input mm_pkg::phase_t phase,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [AW-1:0]  out_data,
  input logic           out_last
);
  import mm_pkg::*;

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  p_last_valid_r5: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  p_final_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (!out_valid && !in_ready));

  p_no_out_loading_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD_A) |-> !out_valid);

  p_idle_closed_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DONE) |-> (!in_ready && !out_valid));
endmodule

bind matmul_stream_cop mm_cop_checker #(.AW(ACC_W)) chk_i (
  .clk(clk), .rst(rst), .phase(phase_q), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last)
);

// File: tb/matmul_stream_cop_tb_top.sv
`timescale 1ns/1ps
module matmul_stream_cop_tb_top;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int AW = 2*W + $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_last;
  logic [AW-1:0] out_data;

  always #4 clk = ~clk;

  matmul_stream_cop #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int n_run = 0, n_fail = 0;
  int Am [N][N];
  int Bm [N][N];
  int cexp [N*N];
  int got = 0;
  int mode = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pv(input int seed, input int idx);
    return ((seed * 37 + idx * 53 + idx * idx * 11) % 256) - 128;
  endfunction

  task automatic fill(input int sa, input int sb);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        Am[r][c] = pv(sa, r*N + c);
        Bm[r][c] = pv(sb, r*N + c + 7);
      end
  endtask

  task automatic compute();
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++) begin
        int s = 0;
        for (int k = 0; k < N; k++) s += Am[i][k] * Bm[k][j];
        cexp[j*N + i] = s;
      end
  endtask

  task automatic send(input int v);
    in_data  = v[W-1:0];
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load_a();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) send(Am[r][c]);
  endtask

  task automatic send_b(input int from, input int upto);
    for (int t = from; t < upto; t++) send(Bm[t % N][t / N]);
  endtask

  task automatic wait_results();
    while (got < N*N) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    // R8: closed after the final result
    chk(!in_ready && !out_valid, "R8 idle after drain", {30'd0, in_ready, out_valid}, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    got = 0;
  endtask

  // Output collector: checks R3, R4, R5, R6
  bit prev_stall = 1'b0;
  logic [AW-1:0] prev_data;
  logic prev_last;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (prev_stall && !rst) begin
        chk(out_valid && out_data == prev_data && out_last == prev_last,
            "R6 hold under stall", int'($signed(out_data)), int'($signed(prev_data)));
      end
      case (mode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) != 0;
        default: out_ready = 1'b0;
      endcase
      if (out_valid && out_ready && !rst) begin
        if (got < N*N) begin
          chk(int'($signed(out_data)) == cexp[got], "R3/R4 result value",
              int'($signed(out_data)), cexp[got]);
          chk(out_last == (got == N*N-1), "R5 last flag", int'(out_last),
              int'(got == N*N-1));
        end else begin
          chk(1'b0, "R2 unexpected output", got, N*N);
        end
        got++;
      end
      prev_stall = out_valid && !out_ready && !rst;
      prev_data  = out_data;
      prev_last  = out_last;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // Run 1: plain product after reset
    @(negedge clk);
    do_reset();
    chk(in_ready && !out_valid, "R1 reset state", {30'd0, in_ready, out_valid}, 2);
    mode = 0;
    fill(3, 5);
    compute();
    load_a();
    chk(!out_valid, "R2 no output after A load", int'(out_valid), 0);
    send_b(0, N-1);
    chk(!out_valid, "R2 no output before column closes", int'(out_valid), 0);
    send_b(N-1, N*N);
    wait_results();

    // Run 2: re-arm with retained A, stalled output, start ignored mid-stream
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) Bm[r][c] = pv(11, r*N + c);
    compute();
    got = 0;
    mode = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(in_ready, "R8 start re-arms input", int'(in_ready), 1);
    send_b(0, N+1);
    start = 1'b1;             // R9: ignored while streaming
    @(negedge clk);
    start = 1'b0;
    send_b(N+1, N*N);
    wait_results();

    // Run 3: extreme operands
    do_reset();
    mode = 1;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        Am[r][c] = -128;
        Bm[r][c] = (r == 1 && c == 2) ? 127 : -128;
      end
    compute();
    chk(cexp[0] == 65536, "R3 bench expectation of extreme sum", cexp[0], 65536);
    load_a();
    send_b(0, N*N);
    wait_results();

    // Run 4: blocked output exposes the input stall; start during A load ignored
    do_reset();
    fill(21, 9);
    compute();
    mode = 2;
    start = 1'b1;             // R9: ignored while loading
    @(negedge clk);
    start = 1'b0;
    chk(in_ready, "R9 start while loading leaves input open", int'(in_ready), 1);
    load_a();
    send_b(0, 2*N-1);
    chk(!in_ready, "R7 stall on column last element", int'(in_ready), 0);
    chk(out_valid && got == 0, "R7 previous column still held", got, 0);
    mode = 0;
    send_b(2*N-1, N*N);
    wait_results();

    // Run 5: reset in the middle of streaming, then a full fresh run
    fill(40, 2);
    compute();
    do_reset();
    mode = 2;
    load_a();
    send_b(0, N+2);
    do_reset();
    chk(in_ready && !out_valid, "R10 reset mid-run", {30'd0, in_ready, out_valid}, 2);
    mode = 1;
    fill(55, 17);
    compute();
    load_a();
    send_b(0, N*N);
    wait_results();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule